// File: doc/BRIEF.md
# Lane-Serial Texel Pair Fetcher

This block turns one scanline segment of per-pixel lane state into colours. A sprite pipeline offers the state of `SEG_LEN` pixels as three parallel vectors: a covered bit, a half-select bit and a texel-pair address for each pixel. When the fetcher is idle it copies the whole segment in one cycle and acknowledges the copy. From then on the producer may start work on the next line. The fetcher then walks the copy one pixel per step. Each step takes the pixel at the head of the copy and shifts the rest down by one position.

For a covered pixel the fetcher needs a 32-bit texel-pair word. If the pair address matches the word it fetched most recently in this segment, it uses the held word and issues no read. Otherwise it raises a request on a shared texel memory port and waits for a grant. The word arrives exactly one cycle after the grant. An uncovered pixel takes the background colour input. Every pixel produces one 16-bit write into a destination buffer that two fetchers share. An even-numbered instance fills entries 0 to `SEG_LEN-1` and an odd-numbered instance fills entries `SEG_LEN` to `2*SEG_LEN-1`. After the last write the fetcher raises done and holds it until the consumer acknowledges.

Top module: `texpair_fetch`

## Requirements
- R1: After reset, `done_o`, `mem_req_o`, `dst_we_o` and `seg_taken_o` are all low.
- R2: While idle with `seg_ready_i` high, `seg_taken_o` is high in that same cycle and the lane vectors are copied at the next clock edge. Changes to the lane inputs after that edge have no effect on the segment being processed.
- R3: Each segment produces exactly `SEG_LEN` destination writes. The k-th write goes to destination address base+k and carries pixel k's result, where pixel k is bit k of `lane_cov_i` and `lane_half_i` and field `lane_addr_i[k*ADDR_W +: ADDR_W]`.
- R4: A pixel whose covered bit is 0 writes `bg_color_i` and causes no memory request.
- R5: A covered pixel whose pair address differs from the held pair requests that address. It also requests when no pair has yet been fetched in the current segment. The pixel is written in the cycle after the grant, using `mem_rdata_i` from that cycle.
- R6: A covered pixel whose pair address equals the most recently fetched pair of the same segment issues no request and uses the held word. Uncovered pixels in between do not disturb the held word. The held pair is discarded when a new segment is taken.
- R7: The half-select bit picks the colour: 0 selects bits [15:0] of the pair word and 1 selects bits [31:16].
- R8: While a request is not granted, `mem_req_o` stays high and `mem_addr_o` stays constant, and no pixel is skipped.
- R9: With an even `INST_ID` the destination addresses lie in 0..`SEG_LEN-1`; with an odd one they lie in `SEG_LEN`..`2*SEG_LEN-1`.
- R10: `done_o` rises after the last write of a segment. It stays high with no writes, no requests and no new segment taken until `done_ack_i` is seen. The fetcher is then idle with `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seg_ready_i | input | 1 | Producer has a complete segment on the lane inputs |
| seg_taken_o | output | 1 | Segment copied this cycle; producer may overwrite |
| lane_cov_i | input | SEG_LEN | Per-pixel covered flag |
| lane_half_i | input | SEG_LEN | Per-pixel half select within the pair word |
| lane_addr_i | input | SEG_LEN*ADDR_W | Per-pixel texel-pair address, pixel k at bits k*ADDR_W |
| bg_color_i | input | PX_W | Colour for uncovered pixels |
| mem_req_o | output | 1 | Texel memory read request |
| mem_addr_o | output | ADDR_W | Requested pair address |
| mem_gnt_i | input | 1 | Grant from the shared texel memory |
| mem_rdata_i | input | 2*PX_W | Pair word, valid the cycle after a grant |
| dst_we_o | output | 1 | Destination buffer write enable |
| dst_addr_o | output | clog2(2*SEG_LEN) | Destination buffer address |
| dst_data_o | output | PX_W | Destination colour |
| done_o | output | 1 | Segment written; waiting for acknowledge |
| done_ack_i | input | 1 | Consumer acknowledge of done |

## Verification
The assertions rely on the texel memory arbiter behaving as a well-formed partner. It may grant only while a request is up, and it must return data exactly one cycle after each grant. They also rely on the consumer raising `done_ack_i` at some point after done. The bench grants through its own memory models from the request and a pseudo-random stall bit, and returns a word computed from the granted address. It raises the acknowledge only after a deliberate wait during which done is observed. Lane inputs change only on falling edges. They are scrambled right after each copy is taken, so the R2 independence is exercised.

// File: rtl/texpair_fetch.sv
module texpair_fetch #(
  parameter int SEG_LEN = 80,
  parameter int ADDR_W  = 16,
  parameter int PX_W    = 16,
  parameter int INST_ID = 0,
  localparam int DW = 2 * PX_W,
  localparam int AW = $clog2(2 * SEG_LEN),
  localparam int IW = $clog2(SEG_LEN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      seg_ready_i,
  output logic                      seg_taken_o,
  input  logic [SEG_LEN-1:0]        lane_cov_i,
  input  logic [SEG_LEN-1:0]        lane_half_i,
  input  logic [SEG_LEN*ADDR_W-1:0] lane_addr_i,
  input  logic [PX_W-1:0]           bg_color_i,
  output logic                      mem_req_o,
  output logic [ADDR_W-1:0]         mem_addr_o,
  input  logic                      mem_gnt_i,
  input  logic [DW-1:0]             mem_rdata_i,
  output logic                      dst_we_o,
  output logic [AW-1:0]             dst_addr_o,
  output logic [PX_W-1:0]           dst_data_o,
  output logic                      done_o,
  input  logic                      done_ack_i
);

  localparam logic [AW-1:0] BASE = (INST_ID % 2 == 1) ? AW'(SEG_LEN) : '0;
  localparam logic [IW-1:0] LAST = IW'(SEG_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_DONE} st_t;
  st_t st;

  logic [SEG_LEN-1:0]        cov_q, half_q;
  logic [SEG_LEN*ADDR_W-1:0] addr_q;
  logic [IW-1:0]             idx;
  logic                      held_ok;
  logic [ADDR_W-1:0]         held_addr;
  logic [DW-1:0]             held_word;

  logic              head_cov, head_half, hit, step, last;
  logic [ADDR_W-1:0] head_addr;
  logic [DW-1:0]     word;

  assign head_cov  = cov_q[0];
  assign head_half = half_q[0];
  assign head_addr = addr_q[ADDR_W-1:0];
  assign hit       = held_ok && (held_addr == head_addr);
  assign step      = !head_cov || hit;
  assign last      = (idx == LAST);

  assign seg_taken_o = (st == S_IDLE) && seg_ready_i;
  assign mem_req_o   = (st == S_RUN) && head_cov && !hit;
  assign mem_addr_o  = head_addr;
  assign done_o      = (st == S_DONE);

  assign word       = (st == S_WAIT) ? mem_rdata_i : held_word;
  assign dst_we_o   = ((st == S_RUN) && step) || (st == S_WAIT);
  assign dst_addr_o = BASE + AW'(idx);
  assign dst_data_o = !head_cov ? bg_color_i
                    : (head_half ? word[DW-1:PX_W] : word[PX_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cov_q     <= '0;
      half_q    <= '0;
      addr_q    <= '0;
      idx       <= '0;
      held_ok   <= 1'b0;
      held_addr <= '0;
      held_word <= '0;
    end else begin
      case (st)
        S_IDLE: if (seg_ready_i) begin
          cov_q   <= lane_cov_i;
          half_q  <= lane_half_i;
          addr_q  <= lane_addr_i;
          idx     <= '0;
          held_ok <= 1'b0;
          st      <= S_RUN;
        end
        S_RUN: if (step) begin
          cov_q  <= cov_q >> 1;
          half_q <= half_q >> 1;
          addr_q <= addr_q >> ADDR_W;
          if (last) st <= S_DONE;
          else idx <= idx + 1'b1;
        end else if (mem_gnt_i) begin
          st <= S_WAIT;
        end
        S_WAIT: begin
          held_ok   <= 1'b1;
          held_addr <= head_addr;
          held_word <= mem_rdata_i;
          cov_q     <= cov_q >> 1;
          half_q    <= half_q >> 1;
          addr_q    <= addr_q >> ADDR_W;
          if (last) st <= S_DONE;
          else begin
            idx <= idx + 1'b1;
            st  <= S_RUN;
          end
        end
        default: if (done_ack_i) st <= S_IDLE;
      endcase
    end
  end

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  a_r5_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_gnt_i |=> dst_we_o && !mem_req_o);

  a_r9_dst_window: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we_o |-> (dst_addr_o >= BASE) && (dst_addr_o < BASE + AW'(SEG_LEN)));

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !done_ack_i |=> done_o);

  a_r10_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !dst_we_o && !mem_req_o && !seg_taken_o);

  a_r2_take_starts: assert property (@(posedge clk) disable iff (!rst_n)
    seg_taken_o |=> !done_o && !seg_taken_o);

endmodule

// File: tb/tb_texpair_fetch.sv
module tb_texpair_fetch;
  localparam int N  = 80;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic          seg_ready = 0, ack = 0;
  logic [N-1:0]  cov = '0, half = '0;
  logic [N*AW-1:0] addrs = '0;
  logic [15:0]   bg = '0;

  logic taken0, req0, gnt0, we0, done0;
  logic [15:0] maddr0, wdata0;
  logic [31:0] rdata0;
  logic [7:0]  waddr0;
  logic taken1, req1, we1, done1;
  logic [15:0] maddr1, wdata1;
  logic [31:0] rdata1;
  logic [7:0]  waddr1;

  logic [7:0]  lfsr = 8'h5B;
  logic [15:0] ga0 = '0, ga1 = '0;

  function automatic logic [31:0] mem_word(input logic [15:0] a);
    return {a ^ 16'h5A3C, a + 16'h0F0F};
  endfunction

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    ga0  <= maddr0;
    ga1  <= maddr1;
  end
  assign gnt0   = req0 && (lfsr[1:0] != 2'b00);
  assign rdata0 = mem_word(ga0);
  assign rdata1 = mem_word(ga1);

  texpair_fetch #(.SEG_LEN(N), .ADDR_W(AW), .PX_W(16), .INST_ID(0)) dut (
    .clk, .rst_n, .seg_ready_i(seg_ready), .seg_taken_o(taken0),
    .lane_cov_i(cov), .lane_half_i(half), .lane_addr_i(addrs), .bg_color_i(bg),
    .mem_req_o(req0), .mem_addr_o(maddr0), .mem_gnt_i(gnt0), .mem_rdata_i(rdata0),
    .dst_we_o(we0), .dst_addr_o(waddr0), .dst_data_o(wdata0),
    .done_o(done0), .done_ack_i(ack));

  texpair_fetch #(.SEG_LEN(N), .ADDR_W(AW), .PX_W(16), .INST_ID(1)) dut_hi (
    .clk, .rst_n, .seg_ready_i(seg_ready), .seg_taken_o(taken1),
    .lane_cov_i(cov), .lane_half_i(half), .lane_addr_i(addrs), .bg_color_i(bg),
    .mem_req_o(req1), .mem_addr_o(maddr1), .mem_gnt_i(req1), .mem_rdata_i(rdata1),
    .dst_we_o(we1), .dst_addr_o(waddr1), .dst_data_o(wdata1),
    .done_o(done1), .done_ack_i(ack));

  int checks = 0, errors = 0;
  logic        ev [N];
  logic        eh [N];
  logic [15:0] ea [N];
  logic [15:0] ebg;
  int wk0 = 0, wk1 = 0, nreq0 = 0, nreq1 = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_px(input int k);
    logic [31:0] w;
    w = mem_word(ea[k]);
    if (!ev[k]) return ebg;
    return eh[k] ? w[31:16] : w[15:0];
  endfunction

  always @(negedge clk) if (rst_n) begin
    if (req0 && gnt0) nreq0++;
    if (req1) nreq1++;
    if (we0) begin
      if (wk0 < N) begin
        chk(waddr0 == 8'(wk0), "R3/R9 even address", waddr0, wk0);
        chk(wdata0 == exp_px(wk0), "R3/R4/R5/R7 even data", wdata0, exp_px(wk0));
      end else chk(0, "R3 extra even write", wk0, N);
      wk0++;
    end
    if (we1) begin
      if (wk1 < N) begin
        chk(waddr1 == 8'(N + wk1), "R9 odd address", waddr1, N + wk1);
        chk(wdata1 == exp_px(wk1), "R9 odd data", wdata1, exp_px(wk1));
      end else chk(0, "R3 extra odd write", wk1, N);
      wk1++;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic run_seg(input int p);
    int er;
    logic [15:0] last_a;
    logic have;
    for (int k = 0; k < N; k++) begin
      case (p)
        0: begin ev[k] = 0; eh[k] = k[0]; ea[k] = 16'(k); end
        1: begin ev[k] = 1; eh[k] = k[0]; ea[k] = 16'h0123; end
        2: begin ev[k] = 1; eh[k] = k[1]; ea[k] = 16'h1000 + 16'(k); end
        3: begin ev[k] = ((k * 7) % 5 != 0); eh[k] = ((k * 5) % 3 == 0); ea[k] = 16'h0200 + 16'(k / 3); end
        4: begin ev[k] = (k % 4 != 2); eh[k] = k[0] ^ k[2]; ea[k] = 16'h0300 + 16'(k / 8); end
        5: begin ev[k] = 1; eh[k] = k[1]; ea[k] = k[0] ? 16'h0051 : 16'h0050; end
        default: begin ev[k] = 1; eh[k] = k[0]; ea[k] = 16'h104F; end
      endcase
      cov[k] = ev[k];
      half[k] = eh[k];
      addrs[k*AW +: AW] = ea[k];
    end
    ebg = 16'hB000 + 16'(p);
    bg = ebg;
    er = 0; have = 0; last_a = '0;
    for (int k = 0; k < N; k++)
      if (ev[k] && !(have && last_a == ea[k])) begin er++; have = 1; last_a = ea[k]; end
    wk0 = 0; wk1 = 0; nreq0 = 0; nreq1 = 0;
    @(negedge clk);
    seg_ready = 1;
    #1 chk(taken0 == 1, "R2 taken while idle", taken0, 1);
    @(negedge clk);
    seg_ready = 0;
    cov = ~cov; half = ~half; addrs = ~addrs;
    for (int t = 0; t < 2000 && !(done0 && done1); t++) @(negedge clk);
    #1;
    chk(done0 == 1, "R10 done raised", done0, 1);
    chk(wk0 == N, "R3 even write count", wk0, N);
    chk(wk1 == N, "R3 odd write count", wk1, N);
    chk(nreq0 == er, "R5/R6 even request count", nreq0, er);
    chk(nreq1 == er, "R6 odd request count", nreq1, er);
    seg_ready = 1;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk); #1;
      chk(done0 == 1 && taken0 == 0 && we0 == 0 && req0 == 0, "R10 hold without ack",
          {done0, taken0, we0, req0}, 4'b1000);
    end
    seg_ready = 0;
    ack = 1;
    @(negedge clk);
    ack = 0;
    #1 chk(done0 == 0 && done1 == 0, "R10 idle after ack", {done0, done1}, 0);
    chk(wk0 == N, "R10 no writes while done", wk0, N);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 chk({done0, req0, we0, taken0} == 0, "R1 reset outputs", {done0, req0, we0, taken0}, 0);
    rst_n = 1;
    @(negedge clk);
    #1 chk({done0, req0, we0, taken0} == 0, "R1 idle after reset", {done0, req0, we0, taken0}, 0);
    run_seg(0);
    run_seg(1);
    run_seg(2);
    run_seg(6);
    run_seg(3);
    run_seg(4);
    run_seg(5);
    run_seg(1);
    summary();
  end
endmodule